// File: doc/BRIEF.md
# Nibble-State Authentication Stream Generator

This block turns a two-nibble host seed into an unending serial authentication stream. It keeps a sixteen-entry state memory of four-bit values. When the host presents a seed, the two seed nibbles fill the two lowest entries. A fixed key parameter supplies the other fourteen entries. From then on the block loops forever. In each loop it scrambles the memory with three mixing rounds, then shifts out a run of state bits, one per strobe.

A mixing round is a loop. Its pass count depends on the data, and one pass does a fixed sequence of nibble additions, comparisons and an inversion, then a carry-style chain through the upper part of the memory. Every sum wraps modulo 16. The memory is never cleared between loops, so each output burst depends on every round since the seed. The block does one memory operation per clock. It raises `busy` while it scrambles.

Top module: `authgen_top`

## Requirements
- R1: After reset `ser_out`, `bit_strobe` and `busy` are 0. They stay 0, with no strobe, for as long as `seed_valid` is not asserted.
- R2: When `seed_valid` is sampled high in the idle state, entry 0 takes `seed_lo` and entry 1 takes `seed_hi`. Entry k (k = 2..15) takes bits [4(k-2)+3 : 4(k-2)] of the `KEY` parameter. `busy` is 1 in the clock after that sampling edge.
- R3: One pass uses a counter x. It adds x+1 to entry 1. It sets b = 7 if (15 - e3) > e2 and b = 6 otherwise, then adds e3 to entry b-3. It adds e2+1 to entry 3. It writes ~(e2+e1+1) to entry 2. It saves a = e[b-1]. If e[b-2] > 7 it clears entry b-1, then adds e[b-2]+8 to entry b-1. It adds e[b-3] to entry b-2. Finally, for k = b..15 in order, it sets a = a + e[k] + 1 and writes a to entry k. Every step uses the values as updated by the steps before it, and all sums are modulo 16.
- R4: At the start of a round x is loaded from entry 15. Passes run with x = e15, e15-1, ..., 0, which is e15+1 passes. The round ends when x would wrap to 15.
- R5: Each output burst comes after exactly three rounds on the same memory. The memory carries over from one burst to the next with no reload.
- R6: After the three rounds, a burst sends N = e7 + 1 bits (1 to 16). These are the least significant bits of entries 0, 1, ..., N-1, in that order.
- R7: `bit_strobe` is high for exactly one clock per bit and is never high in two consecutive clocks. `ser_out` changes only in clocks where `bit_strobe` is low, so it is stable while the strobe is high.
- R8: `busy` is high while rounds run. `bit_strobe` is never high while `busy` is high.
- R9: Once started, the block ignores `seed_valid` and the seed nibbles. Only reset returns it to the idle state.
- R10: The clock after the last strobe of a burst, `busy` is high again and the next three rounds begin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| seed_valid | input | 1 | Seed strobe, accepted only when idle |
| seed_lo | input | 4 | Seed nibble for state entry 0 |
| seed_hi | input | 4 | Seed nibble for state entry 1 |
| ser_out | output | 1 | Serial stream bit |
| bit_strobe | output | 1 | One-clock marker for each valid bit |
| busy | output | 1 | High while mixing rounds run |

## Verification
The paths that are hardest to reach from the ports sit deep inside a round. One is the b = 6 branch, where entry 3 is added to itself. Another is the clear of entry b-1 when e[b-2] exceeds 7. A third is the full 16-bit burst length. None of these can be set up directly, because the state is reachable only through the seed and the evolving rounds. The stimulus therefore runs several seeds, including all-zero and all-ones, and keeps each seed running for several bursts. A behavioural reference model, built on integer arrays, predicts every bit and every burst length. Because the memory carries over between bursts, any wrong branch shows up in the stream. A seed pulse fired in the middle of a run tests that the running state is left untouched.

// File: rtl/authgen_pkg.sv
package authgen_pkg;
  localparam int NIB_W   = 4;
  localparam int DEPTH   = 16;
  localparam int IDX_W   = $clog2(DEPTH);
  localparam int KEY_W   = (DEPTH - 2) * NIB_W;
  localparam int LEN_IDX = 7;

  typedef logic [NIB_W-1:0] nib_t;
  typedef logic [IDX_W-1:0] idx_t;

  typedef enum logic [2:0] {
    E_IDLE, E_ADDX, E_PICK, E_BUMP3, E_INV2, E_FOLD, E_CARRY, E_CHAIN
  } eng_state_e;

  typedef enum logic [2:0] {
    Q_IDLE, Q_RGO, Q_RWAIT, Q_SGO, Q_SWAIT
  } seq_state_e;

  typedef enum logic [1:0] {
    S_IDLE, S_LOAD, S_SETTLE, S_STROBE
  } ser_state_e;

  function automatic nib_t nib_add3(nib_t p, nib_t q, nib_t r);
    return p + q + r;
  endfunction

  function automatic idx_t pick_base(nib_t e2, nib_t e3);
    return ((4'hF - e3) > e2) ? idx_t'(7) : idx_t'(6);
  endfunction

  function automatic nib_t fold_val(nib_t cur, nib_t lower);
    nib_t base;
    base = (lower > 4'd7) ? 4'd0 : cur;
    return base + lower + 4'd8;
  endfunction

  function automatic nib_t inv_mix(nib_t e2, nib_t e1);
    return ~(e2 + e1 + 4'd1);
  endfunction
endpackage

// File: rtl/authgen_round_engine.sv
module authgen_round_engine
  import authgen_pkg::*;
#(
  parameter logic [KEY_W-1:0] KEY = 56'h3D9A1F27C6B8E4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  nib_t seed_lo_i,
  input  nib_t seed_hi_i,
  input  logic go_i,
  output logic done_o,
  input  idx_t rd_idx_i,
  output nib_t rd_nib_o,
  output nib_t len_nib_o
);
  nib_t       mem [DEPTH];
  eng_state_e state;
  nib_t       x_q;
  nib_t       a_q;
  idx_t       b_q;

  idx_t pick_b, pick_lo;
  idx_t b_m1, b_m2, b_m3;
  nib_t chain_v;

  always_comb begin
    pick_b  = pick_base(mem[2], mem[3]);
    pick_lo = pick_b - idx_t'(3);
    b_m1    = b_q - idx_t'(1);
    b_m2    = b_q - idx_t'(2);
    b_m3    = b_q - idx_t'(3);
    chain_v = nib_add3(a_q, mem[b_q], 4'd1);
  end

  assign done_o    = (state == E_CHAIN) && (b_q == idx_t'(DEPTH-1)) && (x_q == '0);
  assign rd_nib_o  = mem[rd_idx_i];
  assign len_nib_o = mem[LEN_IDX];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= E_IDLE;
      x_q   <= '0;
      a_q   <= '0;
      b_q   <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      case (state)
        E_IDLE: begin
          if (load_i) begin
            mem[0] <= seed_lo_i;
            mem[1] <= seed_hi_i;
            for (int k = 2; k < DEPTH; k++) mem[k] <= KEY[NIB_W*(k-2) +: NIB_W];
          end else if (go_i) begin
            x_q   <= mem[DEPTH-1];
            state <= E_ADDX;
          end
        end
        E_ADDX: begin
          mem[1] <= nib_add3(mem[1], x_q, 4'd1);
          state  <= E_PICK;
        end
        E_PICK: begin
          b_q          <= pick_b;
          mem[pick_lo] <= mem[pick_lo] + mem[3];
          state        <= E_BUMP3;
        end
        E_BUMP3: begin
          mem[3] <= nib_add3(mem[3], mem[2], 4'd1);
          state  <= E_INV2;
        end
        E_INV2: begin
          mem[2] <= inv_mix(mem[2], mem[1]);
          state  <= E_FOLD;
        end
        E_FOLD: begin
          a_q       <= mem[b_m1];
          mem[b_m1] <= fold_val(mem[b_m1], mem[b_m2]);
          state     <= E_CARRY;
        end
        E_CARRY: begin
          mem[b_m2] <= mem[b_m2] + mem[b_m3];
          state     <= E_CHAIN;
        end
        E_CHAIN: begin
          mem[b_q] <= chain_v;
          a_q      <= chain_v;
          b_q      <= b_q + idx_t'(1);
          if (b_q == idx_t'(DEPTH-1)) begin
            if (x_q == '0) begin
              state <= E_IDLE;
            end else begin
              x_q   <= x_q - 4'd1;
              state <= E_ADDX;
            end
          end
        end
        default: state <= E_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/authgen_sequencer.sv
module authgen_sequencer
  import authgen_pkg::*;
#(
  parameter int ROUNDS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic seed_valid_i,
  input  logic round_done_i,
  input  logic ser_done_i,
  output logic load_o,
  output logic round_go_o,
  output logic ser_go_o,
  output logic busy_o,
  output logic idle_o
);
  localparam int RC_W = (ROUNDS > 1) ? $clog2(ROUNDS) : 1;
  localparam logic [RC_W-1:0] RC_LAST = RC_W'(ROUNDS - 1);

  seq_state_e      state;
  logic [RC_W-1:0] rcnt;

  assign idle_o     = (state == Q_IDLE);
  assign load_o     = idle_o && seed_valid_i;
  assign round_go_o = (state == Q_RGO);
  assign ser_go_o   = (state == Q_SGO);
  assign busy_o     = (state == Q_RGO) || (state == Q_RWAIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= Q_IDLE;
      rcnt  <= '0;
    end else begin
      case (state)
        Q_IDLE:  if (seed_valid_i) state <= Q_RGO;
        Q_RGO:   state <= Q_RWAIT;
        Q_RWAIT: begin
          if (round_done_i) begin
            if (rcnt == RC_LAST) begin
              rcnt  <= '0;
              state <= Q_SGO;
            end else begin
              rcnt  <= rcnt + 1'b1;
              state <= Q_RGO;
            end
          end
        end
        Q_SGO:   state <= Q_SWAIT;
        Q_SWAIT: if (ser_done_i) state <= Q_RGO;
        default: state <= Q_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/authgen_serializer.sv
module authgen_serializer
  import authgen_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic go_i,
  input  nib_t len_nib_i,
  output idx_t rd_idx_o,
  input  nib_t rd_nib_i,
  output logic ser_o,
  output logic strobe_o,
  output logic done_o
);
  ser_state_e state;
  idx_t       idx_q;
  idx_t       last_q;
  logic       ser_q;

  assign rd_idx_o = idx_q;
  assign ser_o    = ser_q;
  assign strobe_o = (state == S_STROBE);
  assign done_o   = strobe_o && (idx_q == last_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      idx_q  <= '0;
      last_q <= '0;
      ser_q  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (go_i) begin
            idx_q  <= '0;
            last_q <= idx_t'(len_nib_i);
            state  <= S_LOAD;
          end
        end
        S_LOAD: begin
          ser_q <= rd_nib_i[0];
          state <= S_SETTLE;
        end
        S_SETTLE: state <= S_STROBE;
        S_STROBE: begin
          idx_q <= idx_q + idx_t'(1);
          state <= (idx_q == last_q) ? S_IDLE : S_LOAD;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/authgen_top.sv
module authgen_top
  import authgen_pkg::*;
#(
  parameter logic [KEY_W-1:0] KEY    = 56'h3D9A1F27C6B8E4,
  parameter int               ROUNDS = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       seed_valid,
  input  logic [3:0] seed_lo,
  input  logic [3:0] seed_hi,
  output logic       ser_out,
  output logic       bit_strobe,
  output logic       busy
);
  logic seq_idle;
  logic round_done;
  logic last_bit;
  logic load_pulse, round_go, ser_go;
  idx_t rd_idx;
  nib_t rd_nib, len_nib;

  authgen_sequencer #(.ROUNDS(ROUNDS)) seq_u (
    .clk          (clk),
    .rst_n        (rst_n),
    .seed_valid_i (seed_valid),
    .round_done_i (round_done),
    .ser_done_i   (last_bit),
    .load_o       (load_pulse),
    .round_go_o   (round_go),
    .ser_go_o     (ser_go),
    .busy_o       (busy),
    .idle_o       (seq_idle)
  );

  authgen_round_engine #(.KEY(KEY)) eng_u (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (load_pulse),
    .seed_lo_i (seed_lo),
    .seed_hi_i (seed_hi),
    .go_i      (round_go),
    .done_o    (round_done),
    .rd_idx_i  (rd_idx),
    .rd_nib_o  (rd_nib),
    .len_nib_o (len_nib)
  );

  authgen_serializer ser_u (
    .clk       (clk),
    .rst_n     (rst_n),
    .go_i      (ser_go),
    .len_nib_i (len_nib),
    .rd_idx_o  (rd_idx),
    .rd_nib_i  (rd_nib),
    .ser_o     (ser_out),
    .strobe_o  (bit_strobe),
    .done_o    (last_bit)
  );
endmodule

// File: rtl/authgen_chk.sv
module authgen_chk (
  input logic clk,
  input logic rst_n,
  input logic seed_valid,
  input logic busy,
  input logic bit_strobe,
  input logic ser_out,
  input logic seq_idle,
  input logic round_done,
  input logic last_bit
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    seq_idle |-> (!busy && !bit_strobe));

  a_r2_busy_after_seed: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_idle && seed_valid) |=> busy);

  a_r5_round_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    round_done |-> busy);

  a_r7_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    bit_strobe |=> !bit_strobe);

  a_r7_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
    bit_strobe |-> $stable(ser_out));

  a_r8_no_strobe_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !bit_strobe);

  a_r9_no_reentry: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_idle |=> !seq_idle);

  a_r10_rescramble: assert property (@(posedge clk) disable iff (!rst_n)
    last_bit |=> busy);
endmodule

bind authgen_top authgen_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .seed_valid (seed_valid),
  .busy       (busy),
  .bit_strobe (bit_strobe),
  .ser_out    (ser_out),
  .seq_idle   (seq_idle),
  .round_done (round_done),
  .last_bit   (last_bit)
);

// File: tb/authgen_top_tb_top.sv
`timescale 1ns/1ps
module authgen_top_tb_top;
  localparam logic [55:0] TB_KEY = 56'h3D9A1F27C6B8E4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       seed_valid = 1'b0;
  logic [3:0] seed_lo = 4'd0;
  logic [3:0] seed_hi = 4'd0;
  logic       ser_out, bit_strobe, busy;

  always #2.5 clk = ~clk;

  authgen_top #(.KEY(TB_KEY)) dut_i (
    .clk(clk), .rst_n(rst_n), .seed_valid(seed_valid),
    .seed_lo(seed_lo), .seed_hi(seed_hi),
    .ser_out(ser_out), .bit_strobe(bit_strobe), .busy(busy)
  );

  int checks = 0, failures = 0;
  int mm [16];
  int expq [$];
  int cur_n = 0, strobes_seen = 0, cycles_done = 0;
  logic prev_busy = 0, prev_strobe = 0, prev_ser = 0;
  bit want_busy = 0, finished = 0;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // Reference round: integer arithmetic on an array.
  function automatic void mdl_round();
    int start, b, a;
    start = mm[15];
    for (int x = start; x >= 0; x--) begin
      mm[1] = (mm[1] + x + 1) % 16;
      b = ((15 - mm[3]) > mm[2]) ? 7 : 6;
      mm[b-3] = (mm[b-3] + mm[3]) % 16;
      mm[3] = (mm[3] + mm[2] + 1) % 16;
      mm[2] = 15 - ((mm[2] + mm[1] + 1) % 16);
      a = mm[b-1];
      if (mm[b-2] > 7) mm[b-1] = 0;
      mm[b-1] = (mm[b-1] + mm[b-2] + 8) % 16;
      mm[b-2] = (mm[b-2] + mm[b-3]) % 16;
      for (int k = b; k < 16; k++) begin
        a = (a + mm[k] + 1) % 16;
        mm[k] = a;
      end
    end
  endfunction

  function automatic void mdl_fill();
    for (int r = 0; r < 3; r++) mdl_round();
    cur_n = mm[7] + 1;
    for (int k = 0; k < cur_n; k++) expq.push_back(mm[k] % 2);
  endfunction

  always @(negedge clk) begin
    int exp_b;
    if (rst_n) begin
      if (want_busy) begin
        check(busy == 1'b1, "R10 busy after last bit", int'(busy), 1);
        want_busy = 0;
      end
      if (busy && !prev_busy) begin
        if (strobes_seen > 0) check(strobes_seen == cur_n, "R6 bit count", strobes_seen, cur_n);
        strobes_seen = 0;
        cycles_done++;
      end
      if (bit_strobe) begin
        check(!busy, "R8 strobe while busy", int'(busy), 0);
        check(!prev_strobe, "R7 strobe width", int'(prev_strobe), 0);
        check(ser_out == prev_ser, "R7 data setup", int'(ser_out), int'(prev_ser));
        if (expq.size() == 0) mdl_fill();
        exp_b = expq.pop_front();
        check(int'(ser_out) == exp_b, "R2/R3/R4/R5/R6 stream bit", int'(ser_out), exp_b);
        strobes_seen++;
        if (expq.size() == 0) want_busy = 1;
      end
    end
    prev_busy = busy; prev_strobe = bit_strobe; prev_ser = ser_out;
  end

  task automatic do_reset();
    rst_n = 1'b0;
    seed_valid = 1'b0;
    expq.delete();
    strobes_seen = 0;
    want_busy = 0;
    cycles_done = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic seed(int lo, int hi);
    mm[0] = lo; mm[1] = hi;
    for (int k = 2; k < 16; k++) mm[k] = int'((TB_KEY >> (4*(k-2))) & 56'hF);
    @(negedge clk);
    seed_valid = 1'b1; seed_lo = lo[3:0]; seed_hi = hi[3:0];
    @(negedge clk);
    seed_valid = 1'b0;
    check(busy == 1'b1, "R2 busy after seed", int'(busy), 1);
  endtask

  task automatic wait_bursts(int n);
    int target;
    target = cycles_done + n;
    while (cycles_done < target) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      summary();
    end
  end

  initial begin
    bit quiet;
    int f0, c0;
    do_reset();
    // R1: idle and silent without a seed
    check(!busy && !bit_strobe && !ser_out, "R1 reset state", int'(busy) + int'(bit_strobe), 0);
    quiet = 1;
    repeat (40) begin
      @(negedge clk);
      if (busy || bit_strobe || ser_out) quiet = 0;
    end
    check(quiet, "R1 no activity before seed", int'(quiet), 1);

    seed(5, 10);
    wait_bursts(4);

    // R9: seed pulses mid-run must not disturb the stream
    f0 = failures; c0 = cycles_done;
    @(negedge clk);
    seed_valid = 1'b1; seed_lo = 4'd3; seed_hi = 4'd12;
    repeat (25) @(negedge clk);
    seed_valid = 1'b0;
    wait_bursts(2);
    check(failures == f0 && cycles_done > c0, "R9 seed ignored when running", failures - f0, 0);

    do_reset();
    check(!busy && !bit_strobe && !ser_out, "R1 reset mid-run", int'(busy) + int'(bit_strobe), 0);
    seed(0, 0);
    wait_bursts(3);

    do_reset();
    seed(15, 15);
    wait_bursts(3);

    do_reset();
    seed(9, 6);
    wait_bursts(3);

    summary();
  end
endmodule